// File: doc/BRIEF.md
# Max-Log-MAP Soft-In/Soft-Out Component Decoder

This block is one soft-in/soft-out constituent decoder for a four-state recursive systematic convolutional code. The code uses feedback polynomial 1+D+D^2 and feedforward polynomial 1+D^2. For a block of `BLK_LEN` symbols it accepts three values per symbol: a signed channel value for the systematic bit, a signed channel value for the parity bit, and a signed a priori value from the other constituent decoder. For each symbol it returns an extrinsic value and a hard bit decision. All arithmetic stays in the log domain, and every sum of exponentials is replaced by a plain maximum with no correction term.

The decoder works in two phases. In the loading phase it takes one symbol per accepted input. It runs the forward state-metric recursion on that symbol and pushes the forward metrics of the step, together with the symbol's inputs, onto a last-in/first-out store. In the unloading phase it pops one entry per cycle and runs the backward recursion from the end of the block toward its start. From the popped forward metrics, the branch metrics and the current backward metrics it forms the log-likelihood ratio. Results therefore leave in reverse symbol order, each tagged with its index. Because the trellis is not terminated, the backward recursion starts with all four states equal.

Top module: `mlm_dec`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: While `in_ready` is 1 a symbol is taken on every cycle with `in_valid` 1. After `BLK_LEN` symbols `in_ready` falls to 0 for `BLK_LEN` cycles. `in_valid` and the input values during those cycles have no effect on any result. No result appears while a block is loading.
- R3: Starting one cycle after the last symbol is taken, `out_valid` is 1 for `BLK_LEN` consecutive cycles. `out_idx` counts down from `BLK_LEN-1` to 0.
- R4: The trellis state is (s1,s0), with s1 the newest register. For input u the feedback bit is a = u^s1^s0, the parity bit is a^s0 and the next state is (a,s1). The branch metric of a transition is u*(SYS_WT*sys + apr) + p*par for its input bit u and parity bit p.
- R5: The forward metrics start at 0 for state 00 and at -2^(MET_W-2) for the other three states. Each step keeps the maximum of the predecessor metric plus the branch metric, subtracts the new state-00 value from all four, and clips the result to the symmetric `MET_W`-bit range.
- R6: The backward metrics start equal for all states. Each step keeps, per state, the maximum of the branch metric plus the successor's metric, then normalises and clips the same way as R5.
- R7: The LLR is the best metric sum over u=1 transitions minus the best over u=0 transitions. A positive LLR means bit 1. `out_hard` is 1 when the LLR is zero or positive.
- R8: `out_ext` equals LLR - SYS_WT*sys - apr for that symbol, clipped to ±(2^(EXT_W-1)-1).
- R9: In the cycle that carries the index-0 result, `in_ready` is already 1, so the first symbol of the next block can be taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Decoder is loading and takes a symbol |
| in_sys | input | SYM_W | Signed systematic channel value |
| in_par | input | SYM_W | Signed parity channel value |
| in_apr | input | APR_W | Signed a priori value |
| out_valid | output | 1 | Result present |
| out_idx | output | clog2(BLK_LEN) | Symbol index of the result |
| out_ext | output | EXT_W | Signed extrinsic value |
| out_hard | output | 1 | Hard decision bit |

## Verification
Two functions meet in a single cycle: the decoder presents the final, index-0 result of one block, and it takes the first symbol of the following block. The bench provokes this by driving every block straight after the previous one, placing the new symbol on the cycle where the last result is checked. It judges the overlap by confirming `in_ready` is already high there and that the next block's results all match the reference. Garbage inputs held valid during every unloading phase must leave both the current and the next block's results exact.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

  typedef logic [1:0] trl_st_t;

  typedef enum logic {PH_FWD, PH_BWD} ph_t;

  // feedback 1+D+D^2: a = u ^ s1 ^ s0 ; next state {a, s1}
  function automatic trl_st_t trl_next(trl_st_t s, logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return {a, s[1]};
  endfunction

  // feedforward 1+D^2: parity = a ^ s0
  function automatic logic trl_par(trl_st_t s, logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return a ^ s[0];
  endfunction

  // branch metric table index: {input bit, parity bit}
  function automatic logic [1:0] gam_idx(trl_st_t s, logic u);
    return {u, trl_par(s, u)};
  endfunction

  // symmetric clip to a signed width w
  function automatic int clip_int(int v, int w);
    int hi;
    hi = (1 << (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi) return -hi;
    return v;
  endfunction

endpackage

// File: rtl/mlm_bmu.sv
module mlm_bmu #(
  parameter int SYM_W  = 8,
  parameter int APR_W  = 10,
  parameter int GW     = 13,
  parameter int SYS_WT = 1
) (
  input  logic signed [SYM_W-1:0] sys,
  input  logic signed [SYM_W-1:0] par,
  input  logic signed [APR_W-1:0] apr,
  output logic signed [GW-1:0]    gam [4]
);

  // entry index bit1 = input bit, bit0 = parity bit
  always_comb begin
    int us;
    us = SYS_WT * int'(sys) + int'(apr);
    for (int i = 0; i < 4; i++) begin
      gam[i] = GW'((i[1] ? us : 0) + (i[0] ? int'(par) : 0));
    end
  end

endmodule

// File: rtl/mlm_acs.sv
module mlm_acs
  import mlm_pkg::*;
#(
  parameter int MW       = 12,
  parameter int GW       = 13,
  parameter bit BACKWARD = 1'b0
) (
  input  logic signed [MW-1:0] met_in  [4],
  input  logic signed [GW-1:0] gam     [4],
  output logic signed [MW-1:0] met_out [4]
);

  int best [4];

  generate
    if (!BACKWARD) begin : g_fwd
      // each next state keeps its best incoming path
      always_comb begin
        int c;
        trl_st_t nx;
        for (int i = 0; i < 4; i++) best[i] = -(1 << 30);
        for (int s = 0; s < 4; s++) begin
          for (int uu = 0; uu < 2; uu++) begin
            nx = trl_next(trl_st_t'(s), uu[0]);
            c  = int'(met_in[s]) + int'(gam[gam_idx(trl_st_t'(s), uu[0])]);
            if (c > best[nx]) best[nx] = c;
          end
        end
      end
    end else begin : g_bwd
      // each state keeps its best outgoing path
      always_comb begin
        int c;
        trl_st_t nx;
        for (int i = 0; i < 4; i++) best[i] = -(1 << 30);
        for (int s = 0; s < 4; s++) begin
          for (int uu = 0; uu < 2; uu++) begin
            nx = trl_next(trl_st_t'(s), uu[0]);
            c  = int'(gam[gam_idx(trl_st_t'(s), uu[0])]) + int'(met_in[nx]);
            if (c > best[s]) best[s] = c;
          end
        end
      end
    end
  endgenerate

  // normalise against state 00, then clip
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      met_out[i] = MW'(clip_int(best[i] - best[0], MW));
    end
  end

endmodule

// File: rtl/mlm_lifo.sv
module mlm_lifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 74
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[AW'(level - LW'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else if (push) begin
      mem[AW'(level)] <= wdata;
      level <= level + LW'(1);
    end else if (pop) begin
      level <= level - LW'(1);
    end
  end

  // R2
  lifo_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LW'(DEPTH)));
  // R3
  lifo_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0));
  // R2
  lifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/mlm_dec.sv
module mlm_dec
  import mlm_pkg::*;
#(
  parameter int BLK_LEN = 8,
  parameter int SYM_W   = 8,
  parameter int APR_W   = 10,
  parameter int MET_W   = 12,
  parameter int EXT_W   = 10,
  parameter int SYS_WT  = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic signed [SYM_W-1:0]      in_sys,
  input  logic signed [SYM_W-1:0]      in_par,
  input  logic signed [APR_W-1:0]      in_apr,
  output logic                         out_valid,
  output logic [$clog2(BLK_LEN)-1:0]   out_idx,
  output logic signed [EXT_W-1:0]      out_ext,
  output logic                         out_hard
);

  localparam int IW    = $clog2(BLK_LEN);
  localparam int LW    = $clog2(BLK_LEN + 1);
  localparam int MAXW  = (SYM_W > APR_W) ? SYM_W : APR_W;
  localparam int GW    = MAXW + $clog2(SYS_WT + 1) + 2;
  localparam int ENT_W = 4 * MET_W + 2 * SYM_W + APR_W;
  localparam int NEG0  = -(1 << (MET_W - 2));

  ph_t phase;
  logic acc, pop;
  logic signed [MET_W-1:0] alpha_q [4];
  logic signed [MET_W-1:0] alpha_nx[4];
  logic signed [MET_W-1:0] beta_q  [4];
  logic signed [MET_W-1:0] beta_nx [4];
  logic signed [MET_W-1:0] ra      [4];
  logic signed [GW-1:0]    gf      [4];
  logic signed [GW-1:0]    gb      [4];
  logic [ENT_W-1:0]        wr_ent, rd_ent;
  logic [LW-1:0]           level;
  logic signed [SYM_W-1:0] r_sys, r_par;
  logic signed [APR_W-1:0] r_apr;
  int                      llr_w;
  logic                    hard_w;
  logic signed [EXT_W-1:0] ext_w;

  assign in_ready = (phase == PH_FWD);
  assign acc      = in_ready && in_valid;
  assign pop      = (phase == PH_BWD);

  assign wr_ent = {alpha_q[3], alpha_q[2], alpha_q[1], alpha_q[0], in_sys, in_par, in_apr};
  assign {ra[3], ra[2], ra[1], ra[0], r_sys, r_par, r_apr} = rd_ent;

  mlm_bmu #(.SYM_W(SYM_W), .APR_W(APR_W), .GW(GW), .SYS_WT(SYS_WT)) u_bm_f (
    .sys(in_sys), .par(in_par), .apr(in_apr), .gam(gf));

  mlm_bmu #(.SYM_W(SYM_W), .APR_W(APR_W), .GW(GW), .SYS_WT(SYS_WT)) u_bm_b (
    .sys(r_sys), .par(r_par), .apr(r_apr), .gam(gb));

  mlm_acs #(.MW(MET_W), .GW(GW), .BACKWARD(1'b0)) u_fwd (
    .met_in(alpha_q), .gam(gf), .met_out(alpha_nx));

  mlm_acs #(.MW(MET_W), .GW(GW), .BACKWARD(1'b1)) u_bwd (
    .met_in(beta_q), .gam(gb), .met_out(beta_nx));

  mlm_lifo #(.DEPTH(BLK_LEN), .DW(ENT_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(acc), .pop(pop),
    .wdata(wr_ent), .rdata(rd_ent), .level(level));

  // soft output: best u=1 path minus best u=0 path
  always_comb begin
    int m1, m0, c;
    m1 = -(1 << 30);
    m0 = -(1 << 30);
    for (int s = 0; s < 4; s++) begin
      for (int uu = 0; uu < 2; uu++) begin
        c = int'(ra[s]) + int'(gb[gam_idx(trl_st_t'(s), uu[0])])
          + int'(beta_q[trl_next(trl_st_t'(s), uu[0])]);
        if (uu == 1) begin
          if (c > m1) m1 = c;
        end else if (c > m0) begin
          m0 = c;
        end
      end
    end
    llr_w = m1 - m0;
  end

  assign hard_w = (llr_w >= 0);
  assign ext_w  = EXT_W'(clip_int(llr_w - SYS_WT * int'(r_sys) - int'(r_apr), EXT_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_FWD;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_ext   <= '0;
      out_hard  <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        alpha_q[i] <= (i == 0) ? '0 : MET_W'(NEG0);
        beta_q[i]  <= '0;
      end
    end else begin
      out_valid <= pop;
      if (acc) begin
        if (level == LW'(BLK_LEN - 1)) begin
          phase <= PH_BWD;
          for (int i = 0; i < 4; i++) begin
            alpha_q[i] <= (i == 0) ? '0 : MET_W'(NEG0);
            beta_q[i]  <= '0;
          end
        end else begin
          for (int i = 0; i < 4; i++) alpha_q[i] <= alpha_nx[i];
        end
      end
      if (pop) begin
        for (int i = 0; i < 4; i++) beta_q[i] <= beta_nx[i];
        out_idx  <= IW'(level - LW'(1));
        out_ext  <= ext_w;
        out_hard <= hard_w;
        if (level == LW'(1)) phase <= PH_FWD;
      end
    end
  end

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) - IW'(1)));
  // R3
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(phase == PH_BWD));
  // R5
  fwd_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_FWD) && (level != '0)) |-> (alpha_q[0] == '0));
  // R6
  bwd_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BWD) |-> (beta_q[0] == '0));
  // R8
  ext_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ext != {1'b1, {(EXT_W-1){1'b0}}}));
  // R9
  tail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_idx == '0)) |-> in_ready);

endmodule

// File: tb/sim_mlm_dec.sv
`timescale 1ns/1ps
module sim_mlm_dec;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [7:0] in_sys = '0;
  logic signed [7:0] in_par = '0;
  logic signed [9:0] in_apr = '0;
  logic out_valid;
  logic [2:0] out_idx;
  logic signed [9:0] out_ext;
  logic out_hard;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  int b_ys [N];
  int b_yp [N];
  int b_la [N];
  int e_ext [N];
  int e_hard [N];

  always #2.5 clk = ~clk;

  mlm_dec #(.BLK_LEN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sys(in_sys), .in_par(in_par), .in_apr(in_apr),
    .out_valid(out_valid), .out_idx(out_idx), .out_ext(out_ext), .out_hard(out_hard));

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % unsigned'(hi - lo + 1));
  endfunction

  // Reference by exhaustive path search over all 2^N input words.
  // Path metric = sum of u*(ys+la) + p*yp, start state 00, any end state.
  function automatic void compute_ref();
    int b1 [N];
    int b0 [N];
    int r1, r2, pm, u, fb, p, llr, e;
    for (int k = 0; k < N; k++) begin
      b1[k] = -(1 << 30);
      b0[k] = -(1 << 30);
    end
    for (int w = 0; w < (1 << N); w++) begin
      r1 = 0;
      r2 = 0;
      pm = 0;
      for (int k = 0; k < N; k++) begin
        u  = (w >> k) & 1;
        fb = u ^ r1 ^ r2;
        p  = fb ^ r2;
        pm += u * (b_ys[k] + b_la[k]) + p * b_yp[k];
        r2 = r1;
        r1 = fb;
      end
      for (int k = 0; k < N; k++) begin
        if (((w >> k) & 1) == 1) begin
          if (pm > b1[k]) b1[k] = pm;
        end else if (pm > b0[k]) begin
          b0[k] = pm;
        end
      end
    end
    for (int k = 0; k < N; k++) begin
      llr = b1[k] - b0[k];
      e = llr - b_ys[k] - b_la[k];
      if (e > 511) e = 511;
      if (e < -511) e = -511;
      e_ext[k]  = e;
      e_hard[k] = (llr >= 0) ? 1 : 0;
    end
  endfunction

  task automatic run_block();
    compute_ref();
    for (int k = 0; k < N; k++) begin
      in_valid = 1'b1;
      in_sys = 8'(b_ys[k]);
      in_par = 8'(b_yp[k]);
      in_apr = 10'(b_la[k]);
      chk(in_ready == 1'b1, "R2 ready while loading", int'(in_ready), 1);
      if (k == 1) chk(out_valid == 1'b0, "R2 no result while loading", int'(out_valid), 0);
      @(posedge clk);
      @(negedge clk);
    end
    chk(in_ready == 1'b0, "R2 busy after full block", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R3 result latency", int'(out_valid), 0);
    // R2: garbage held valid while busy must be ignored
    in_valid = 1'b1;
    in_sys = 8'(rnd(-128, 127));
    in_par = 8'(rnd(-128, 127));
    in_apr = 10'(rnd(-512, 511));
    for (int j = 0; j < N; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1, "R3 result present", int'(out_valid), 1);
      chk(int'(out_idx) == N - 1 - j, "R3 reverse index", int'(out_idx), N - 1 - j);
      // exact match also exercises trellis R4, forward R5, backward R6
      chk(int'(out_ext) == e_ext[N-1-j], "R8 extrinsic", int'(out_ext), e_ext[N-1-j]);
      chk(int'(out_hard) == e_hard[N-1-j], "R7 hard decision", int'(out_hard), e_hard[N-1-j]);
      if (j < N - 1) begin
        chk(in_ready == 1'b0, "R2 busy while unloading", int'(in_ready), 0);
        in_sys = 8'(rnd(-128, 127));
        in_par = 8'(rnd(-128, 127));
        in_apr = 10'(rnd(-512, 511));
      end else begin
        chk(in_ready == 1'b1, "R9 ready with final result", int'(in_ready), 1);
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);

    // all-zero block: every LLR ties at zero, hard must be 1 (R7)
    for (int k = 0; k < N; k++) begin
      b_ys[k] = 0; b_yp[k] = 0; b_la[k] = 0;
    end
    run_block();

    // clean strong codeword, drives extrinsic into the clip (R8)
    begin
      int r1, r2, u, fb, p;
      r1 = 0; r2 = 0;
      for (int k = 0; k < N; k++) begin
        u  = (8'b1011_0010 >> k) & 1;
        fb = u ^ r1 ^ r2;
        p  = fb ^ r2;
        b_ys[k] = u ? 100 : -100;
        b_yp[k] = p ? 100 : -100;
        b_la[k] = u ? 60 : -60;
        r2 = r1; r1 = fb;
      end
    end
    run_block();

    // idle gap: no acceptance without in_valid (R2)
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 idle ready", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R2 idle no result", int'(out_valid), 0);
    end

    // random blocks, back to back (R9)
    for (int b = 0; b < 40; b++) begin
      for (int k = 0; k < N; k++) begin
        b_ys[k] = rnd(-100, 100);
        b_yp[k] = rnd(-100, 100);
        b_la[k] = rnd(-60, 60);
      end
      run_block();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule